// File: doc/BRIEF.md
# CCD Line Pixel-Region Segmenter

This block sits behind the converter of a linear CCD sensor and receives one digitized sample per shift clock. A strobe from the sensor timing generator marks the first element of each line. The block counts elements from that strobe and sorts each one into a region: leading dummy, shielded black reference, effective pixel, or trailing dummy. Anything that arrives after the trailing dummies is dropped.

The black reference samples of each line are averaged into a dark level. That level is subtracted from every effective pixel, and the result saturates at zero. The block emits a valid-qualified stream of exactly the effective pixels in physical order, with first-pixel and last-pixel markers, and reports the dark level of the line once per line. A mode input selects whether the sensor runs with its internal sample-and-hold. In that mode one extra dummy element leads the line, and every boundary moves one element later.

Top module: `ccd_line_segmenter`

## Requirements
- R1: A sample is taken only while `smp_valid` is 1. `line_start` counts only together with `smp_valid`, and its sample becomes element 0 of a new line. `sh_mode` is latched at that strobe and held for the whole line. Samples before the first strobe after reset produce no output.
- R2: With `sh_mode`=0, elements 0..31 are leading dummies, elements 12..29 are black reference, elements 32..2079 are the 2048 effective pixels, and elements 2080..2085 are trailing dummies.
- R3: With `sh_mode`=1, every boundary of R2 moves one element later. Black reference is 13..30, effective pixels are 33..2080, and trailing dummies are 2081..2086.
- R4: The dark level is the sum of the first 16 black reference samples shifted right by 4. The last two black samples do not enter it. `dark_level` updates with a one-cycle `dark_valid` pulse once per line, before the first effective pixel.
- R5: Each output pixel equals its input sample minus the current dark level, or 0 when the sample is not above the dark level. It appears on the outputs one clock after its sample is taken.
- R6: Each completed line yields exactly 2048 `px_valid` outputs in physical order. `px_sol` marks the first of them and `px_eol` the 2048th. Neither marker is ever set without `px_valid`.
- R7: Samples after the trailing dummies and before the next strobe produce no output and do not change the dark level.
- R8: Cycles with `smp_valid`=0 inside a line do not advance the element count, so gaps do not shift region boundaries.
- R9: A strobe that arrives while a line is still short of its 2048 effective pixels raises `line_err` for one cycle. The block then restarts at the new line. A strobe after a complete line, or the first strobe after reset, raises no error.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Marks the current sample as element 0 of a line |
| smp_valid | input | 1 | Current sample is present |
| smp_data | input | DATA_W | Digitized sample |
| sh_mode | input | 1 | 1 = sensor runs with internal sample-and-hold (one extra leading dummy) |
| px_valid | output | 1 | Corrected effective pixel present |
| px_data | output | DATA_W | Dark-corrected pixel, saturated at zero |
| px_sol | output | 1 | First effective pixel of the line |
| px_eol | output | 1 | Last (2048th) effective pixel of the line |
| dark_level | output | DATA_W | Dark level of the current line |
| dark_valid | output | 1 | One-cycle pulse when dark_level updates |
| line_err | output | 1 | One-cycle pulse: line cut short by an early strobe |

## Verification
The assertions check the following properties on every cycle:
- The element count is frozen across input gaps, and the latched mode stays fixed within a line.
- The markers only appear on valid pixels, and the end marker lands only on the 2048th pixel after a start marker.
- No corrected pixel exceeds the sample it came from.
- The dark pulse never lasts two cycles.
- An error pulse only follows an accepted strobe.

Only the bench scenarios can show the following:
- The region boundaries fall on the right elements in each mode.
- The dark level ignores the two last black samples and the samples outside the black run.
- Each pixel value is correct, including those clamped to zero.
- A cut-short line is reported and followed by a clean line.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int unsigned SEG_EFF_PIX  = 2048;
    localparam int unsigned SEG_LEAD     = 32;
    localparam int unsigned SEG_OB_OFS   = 12;
    localparam int unsigned SEG_OB_CNT   = 18;
    localparam int unsigned SEG_TRAIL    = 6;
    localparam int unsigned SEG_ACC_LOG2 = 4;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_LEAD,
        RG_BLACK,
        RG_EFF,
        RG_TRAIL
    } region_e;

    typedef struct packed {
        logic    live;
        region_e region;
        logic    ob_first;
        logic    ob_acc;
        logic    ob_last;
        logic    eff_first;
        logic    eff_last;
    } seg_tag_t;

    // Classify element k of a line given the boundaries of the active mode.
    function automatic seg_tag_t make_tag(
        input logic        live,
        input int unsigned k,
        input int unsigned lead,
        input int unsigned ob_s,
        input int unsigned ob_n,
        input int unsigned acc_n,
        input int unsigned n_eff,
        input int unsigned trail
    );
        seg_tag_t t;
        t        = '0;
        t.live   = live;
        t.region = RG_NONE;
        if (k < lead) begin
            t.region = (k >= ob_s && k < ob_s + ob_n) ? RG_BLACK : RG_LEAD;
        end else if (k < lead + n_eff) begin
            t.region = RG_EFF;
        end else if (k < lead + n_eff + trail) begin
            t.region = RG_TRAIL;
        end
        t.ob_first  = (k == ob_s);
        t.ob_acc    = (k >= ob_s) && (k < ob_s + acc_n);
        t.ob_last   = (k == ob_s + acc_n - 1);
        t.eff_first = (k == lead);
        t.eff_last  = (k == lead + n_eff - 1);
        return t;
    endfunction

endpackage

// File: rtl/seg_region_ctr.sv
module seg_region_ctr
    import seg_pkg::*;
#(
    parameter int unsigned N_EFF  = SEG_EFF_PIX,
    parameter int unsigned LEAD   = SEG_LEAD,
    parameter int unsigned OB_OFS = SEG_OB_OFS,
    parameter int unsigned OB_CNT = SEG_OB_CNT,
    parameter int unsigned TRAIL  = SEG_TRAIL,
    parameter int unsigned ACC_N  = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_start,
    input  logic     smp_valid,
    input  logic     sh_mode,
    output seg_tag_t tag,
    output logic     line_err
);

    localparam int unsigned TOTAL_MAX = LEAD + 1 + N_EFF + TRAIL;
    localparam int unsigned IDX_W     = $clog2(TOTAL_MAX + 1);

    logic             active_q;
    logic             sh_q;
    logic [IDX_W-1:0] idx_q;

    logic             start_hit;
    logic             cur_sh;
    logic [IDX_W-1:0] cur_idx;
    logic             live;

    assign start_hit = line_start && smp_valid;
    assign cur_sh    = start_hit ? sh_mode : sh_q;
    assign cur_idx   = start_hit ? '0 : idx_q;
    assign live      = smp_valid && (start_hit || active_q);

    always_comb begin
        tag = make_tag(live, 32'(cur_idx), LEAD + 32'(cur_sh), OB_OFS + 32'(cur_sh),
                       OB_CNT, ACC_N, N_EFF, TRAIL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sh_q     <= 1'b0;
            idx_q    <= '0;
            line_err <= 1'b0;
        end else begin
            line_err <= start_hit && active_q &&
                        (32'(idx_q) < LEAD + 32'(sh_q) + N_EFF);
            if (start_hit) begin
                active_q <= 1'b1;
                sh_q     <= sh_mode;
                idx_q    <= IDX_W'(1);
            end else if (live && (idx_q < IDX_W'(TOTAL_MAX))) begin
                idx_q    <= idx_q + IDX_W'(1);
            end
        end
    end

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(idx_q) && $stable(active_q)); // R8

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (active_q && !start_hit) |=> (sh_q == $past(sh_q))); // R1

    AST_ERR_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
        line_err |-> $past(active_q)); // R9

endmodule

// File: rtl/seg_dark_acc.sv
module seg_dark_acc
    import seg_pkg::*;
#(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned ACC_LOG2 = SEG_ACC_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  seg_tag_t          tag,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] dark_level,
    output logic              dark_valid
);

    localparam int unsigned SUM_W = DATA_W + ACC_LOG2;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_nxt;
    logic             take;

    assign take    = tag.live && tag.ob_acc;
    assign sum_nxt = (tag.ob_first ? '0 : sum_q) + SUM_W'(smp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q      <= '0;
            dark_level <= '0;
            dark_valid <= 1'b0;
        end else begin
            dark_valid <= 1'b0;
            if (take) begin
                sum_q <= sum_nxt;
                if (tag.ob_last) begin
                    dark_level <= DATA_W'(sum_nxt >> ACC_LOG2);
                    dark_valid <= 1'b1;
                end
            end
        end
    end

    AST_DARK_PULSE: assert property (@(posedge clk) disable iff (rst)
        dark_valid |=> !dark_valid); // R4

    AST_DARK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dark_valid |-> $stable(dark_level)); // R7

endmodule

// File: rtl/seg_pixel_out.sv
module seg_pixel_out
    import seg_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned N_EFF  = SEG_EFF_PIX
) (
    input  logic              clk,
    input  logic              rst,
    input  seg_tag_t          tag,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] dark_level,
    output logic              px_valid,
    output logic [DATA_W-1:0] px_data,
    output logic              px_sol,
    output logic              px_eol
);

    localparam int unsigned CNT_W = $clog2(N_EFF + 1);

    logic              is_eff;
    logic [DATA_W-1:0] corr;

    assign is_eff = tag.live && (tag.region == RG_EFF);
    assign corr   = (smp_data > dark_level) ? (smp_data - dark_level) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            px_valid <= 1'b0;
            px_data  <= '0;
            px_sol   <= 1'b0;
            px_eol   <= 1'b0;
        end else begin
            px_valid <= is_eff;
            px_sol   <= is_eff && tag.eff_first;
            px_eol   <= is_eff && tag.eff_last;
            if (is_eff) begin
                px_data <= corr;
            end
        end
    end

    // Position of the current output within its line, for the checks below.
    logic [CNT_W-1:0] pos_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (px_valid) begin
            pos_q <= px_sol ? CNT_W'(1) : pos_q + CNT_W'(1);
        end
    end

    AST_CLAMP: assert property (@(posedge clk) disable iff (rst)
        px_valid |-> (px_data <= $past(smp_data))); // R5

    AST_MARK_QUAL: assert property (@(posedge clk) disable iff (rst)
        (px_sol || px_eol) |-> (px_valid && !(px_sol && px_eol))); // R6

    AST_PX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (px_valid && !px_sol) |-> (32'(pos_q) < N_EFF)); // R6

    AST_EOL_POS: assert property (@(posedge clk) disable iff (rst)
        px_eol |-> (32'(pos_q) == N_EFF - 1)); // R6

endmodule

// File: rtl/ccd_line_segmenter.sv
module ccd_line_segmenter
    import seg_pkg::*;
#(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned N_EFF    = SEG_EFF_PIX,
    parameter int unsigned LEAD     = SEG_LEAD,
    parameter int unsigned OB_OFS   = SEG_OB_OFS,
    parameter int unsigned OB_CNT   = SEG_OB_CNT,
    parameter int unsigned TRAIL    = SEG_TRAIL,
    parameter int unsigned ACC_LOG2 = SEG_ACC_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              sh_mode,
    output logic              px_valid,
    output logic [DATA_W-1:0] px_data,
    output logic              px_sol,
    output logic              px_eol,
    output logic [DATA_W-1:0] dark_level,
    output logic              dark_valid,
    output logic              line_err
);

    localparam int unsigned ACC_N = 1 << ACC_LOG2;

    seg_tag_t tag;

    seg_region_ctr #(
        .N_EFF (N_EFF),
        .LEAD  (LEAD),
        .OB_OFS(OB_OFS),
        .OB_CNT(OB_CNT),
        .TRAIL (TRAIL),
        .ACC_N (ACC_N)
    ) u_region (
        .clk       (clk),
        .rst       (rst),
        .line_start(line_start),
        .smp_valid (smp_valid),
        .sh_mode   (sh_mode),
        .tag       (tag),
        .line_err  (line_err)
    );

    seg_dark_acc #(
        .DATA_W  (DATA_W),
        .ACC_LOG2(ACC_LOG2)
    ) u_dark (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag),
        .smp_data  (smp_data),
        .dark_level(dark_level),
        .dark_valid(dark_valid)
    );

    seg_pixel_out #(
        .DATA_W(DATA_W),
        .N_EFF (N_EFF)
    ) u_pix (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag),
        .smp_data  (smp_data),
        .dark_level(dark_level),
        .px_valid  (px_valid),
        .px_data   (px_data),
        .px_sol    (px_sol),
        .px_eol    (px_eol)
    );

    AST_ERR_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        line_err |-> $past(line_start && smp_valid)); // R9

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_err |=> !line_err); // R9

endmodule

// File: tb/ccd_line_segmenter_test.sv
module ccd_line_segmenter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        sh_mode = 1'b0;
    logic        px_valid, px_sol, px_eol, dark_valid, line_err;
    logic [11:0] px_data, dark_level;

    always #4 clk = ~clk;

    ccd_line_segmenter uut (
        .clk(clk), .rst(rst), .line_start(line_start), .smp_valid(smp_valid),
        .smp_data(smp_data), .sh_mode(sh_mode), .px_valid(px_valid),
        .px_data(px_data), .px_sol(px_sol), .px_eol(px_eol),
        .dark_level(dark_level), .dark_valid(dark_valid), .line_err(line_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_sh;
    int exp_seed, exp_obv, exp_dark;
    int line_px, sol_cnt, eol_cnt, dv_cnt, err_cnt, zero_cnt;
    bit collect_on = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Stimulus value of element k: black run is a known ramp (last two saturated).
    function automatic int sample(input int k, input bit sh, input int seed, input int obv);
        int obs = 12 + int'(sh);
        if (k >= obs && k < obs + 18) begin
            if (k - obs >= 16) return 4095;
            return obv + ((k - obs) % 7);
        end
        return (seed + k * 29) % 4096;
    endfunction

    function automatic int calc_dark(input int obv);
        int s = 0;
        for (int o = 0; o < 16; o++) s += obv + (o % 7);
        return s >> 4;
    endfunction

    function automatic int exp_pix(input int j);
        int v = sample(32 + int'(exp_sh) + j, exp_sh, exp_seed, exp_obv);
        return (v > exp_dark) ? v - exp_dark : 0;
    endfunction

    always @(negedge clk) begin
        if (!rst && collect_on) begin
            if (px_valid) begin
                chk(px_data == 12'(exp_pix(line_px)), "R5 pixel value",
                    int'(px_data), exp_pix(line_px));
                if (px_sol) begin
                    sol_cnt++;
                    chk(line_px == 0, "R6 start marker position", line_px, 0);
                end
                if (px_eol) begin
                    eol_cnt++;
                    chk(line_px == 2047, "R6 end marker position", line_px, 2047);
                end
                if (px_data == 0) zero_cnt++;
                line_px++;
            end
            if (dark_valid) begin
                dv_cnt++;
                chk(line_px == 0, "R4 dark before first pixel", line_px, 0);
            end
            if (line_err) err_cnt++;
        end
    end

    task automatic drive_line(input bit sh, input int seed, input int obv,
                              input int n_smp, input int gap, input int extra);
        @(negedge clk);
        exp_sh = sh; exp_seed = seed; exp_obv = obv; exp_dark = calc_dark(obv);
        line_px = 0; sol_cnt = 0; eol_cnt = 0; dv_cnt = 0; zero_cnt = 0;
        for (int k = 0; k < n_smp + extra; k++) begin
            if (k > 0) @(negedge clk);
            if (gap > 0 && k > 0 && (k % gap) == 0) begin
                smp_valid = 1'b0; line_start = 1'b0; smp_data = 12'hFFF;
                @(negedge clk);
            end
            smp_valid  = 1'b1;
            line_start = (k == 0);
            sh_mode    = (k == 0) ? sh : !sh;
            smp_data   = (k < n_smp) ? 12'(sample(k, sh, seed, obv)) : 12'hFFF;
        end
        @(negedge clk);
        smp_valid = 1'b0; line_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_full_line(input string tagname);
        chk(line_px == 2048, {tagname, " R6 pixel count"}, line_px, 2048);
        chk(sol_cnt == 1, {tagname, " R6 start markers"}, sol_cnt, 1);
        chk(eol_cnt == 1, {tagname, " R6 end markers"}, eol_cnt, 1);
        chk(dv_cnt == 1, {tagname, " R4 dark pulses"}, dv_cnt, 1);
        chk(int'(dark_level) == exp_dark, {tagname, " R4 dark level"}, int'(dark_level), exp_dark);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!px_valid && !px_sol && !px_eol, "R10 pixel outputs idle", int'(px_valid), 0);
        chk(dark_level == 0 && !dark_valid, "R10 dark outputs idle", int'(dark_level), 0);
        chk(!line_err && px_data == 0, "R10 error and data idle", int'(line_err), 0);
        rst = 1'b0;
        collect_on = 1'b1;
        line_px = 0; dv_cnt = 0; err_cnt = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            smp_valid = 1'b1; line_start = 1'b0; smp_data = 12'(k * 40);
        end
        @(negedge clk); smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(line_px == 0, "R1 no output before first strobe", line_px, 0);
        chk(dv_cnt == 0, "R1 no dark before first strobe", dv_cnt, 0);
    endtask

    task automatic t_plain;
        drive_line(1'b0, 7, 200, 2086, 0, 0);
        check_full_line("plain");
        drive_line(1'b0, 1234, 150, 2086, 0, 0);
        check_full_line("plain2 R2");
        chk(err_cnt == 0, "R9 no error on complete lines", err_cnt, 0);
    endtask

    task automatic t_sh;
        drive_line(1'b1, 555, 300, 2087, 0, 0);
        check_full_line("shmode R3");
    endtask

    task automatic t_clamp;
        drive_line(1'b0, 99, 2500, 2086, 0, 0);
        check_full_line("clamp");
        chk(zero_cnt > 0, "R5 some pixels clamped to zero", zero_cnt, 1);
        chk(zero_cnt < 2048, "R5 some pixels above dark", zero_cnt, 2047);
    endtask

    task automatic t_tail;
        drive_line(1'b1, 31, 100, 2087, 0, 40);
        check_full_line("tail R7");
        chk(err_cnt == 0, "R7 tail causes no error", err_cnt, 0);
    endtask

    task automatic t_gaps;
        drive_line(1'b0, 77, 400, 2086, 3, 0);
        check_full_line("gaps R8");
    endtask

    task automatic t_trunc;
        int e0 = err_cnt;
        drive_line(1'b0, 4000, 250, 32 + 1000, 0, 0);
        chk(line_px == 1000, "R9 truncated pixel count", line_px, 1000);
        chk(eol_cnt == 0, "R9 truncated line has no end marker", eol_cnt, 0);
        chk(err_cnt == e0, "R9 no error before next strobe", err_cnt, e0);
        drive_line(1'b1, 321, 180, 2087, 0, 0);
        chk(err_cnt == e0 + 1, "R9 early strobe flagged once", err_cnt, e0 + 1);
        check_full_line("restart R9");
    endtask

    initial begin
        t_reset();
        t_plain();
        t_sh();
        t_clamp();
        t_tail();
        t_gaps();
        t_trunc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule